// File: doc/BRIEF.md
# Error-Tolerant Wake Pattern Correlator

This block watches one channel's sliced binary data line, sampled once per clock of a 32.768 kHz timebase. It searches for a fixed 16-half-bit wake word. The word is the Manchester form of 0x96 sent most significant bit first, which gives the half-bit sequence 1001011001101001. Each half-bit lasts 12 sample clocks. When the word is found, the block emits a single-cycle wake pulse. Two things make the search tolerant of noise. First, each half-bit is decided by a majority vote over its samples. Second, a programmable number of half-bits that should be zero may read as one. A half-bit that should be one may never read as zero.

The correlator slides its window one sample per clock, so it needs no separate bit-clock recovery. An optional double mode asks for the word twice, back to back, before it wakes. The error budget is applied to each copy on its own. The channel falls into an idle state when its line has shown no transition for a set number of clocks. No wake is generated while the channel is idle. Control inputs can turn the channel off completely or stop only the correlation.

Top module: `wake_correlator`

## Requirements
- R1: In single mode, one clean wake word on a line that otherwise rests low produces exactly one wake pulse. The pulse appears between 182 and 196 clocks after the first sample of the word is presented.
- R2: `wake_pulse` is never high for two clocks in a row, and it is low throughout reset.
- R3: The number of zero-positions allowed to read as one equals 3 minus `tol_code`, with `tol_code` taken as an unsigned 2-bit value (so 0 allows 3 errors, 1 allows 2, 2 allows 1 and 3 allows 0). A word with at most that many such errors wakes the block. One more error gives no wake.
- R4: If any one-position of the word is decided as zero, there is no wake, whatever the tolerance setting.
- R5: A half-bit is decided as one only when more than half of its 12 samples are one. Up to 5 inverted samples in every half-bit still allow a wake. Six inverted samples in a single one-position block the wake.
- R6: With `double_mode` high, a single word gives no wake. Two words sent back to back give exactly one pulse, and it follows the second word.
- R7: In double mode, each of the two words may carry up to the tolerance in zero-position errors. If the second word exceeds the tolerance, there is no wake.
- R8: After 108 clocks with no transition on `data_in`, the channel goes idle and cannot wake. While idle, the half-bit history follows the resting line level, so a word that starts after a long high or low rest is still found.
- R9: While `corr_off` is high or `enable` is low, no wake pulse is produced for any input. Once both are back to their active levels, detection works normally again.
- R10: In double mode, the second match must begin no later than one word length plus one half-bit after the first. If there is a two-half-bit low gap between the words, there is no wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (one sample per edge) |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_in | input | 1 | Sliced data bit from the detector |
| enable | input | 1 | Channel enable; low clears all channel state |
| corr_off | input | 1 | High stops correlation and arming |
| double_mode | input | 1 | High requires two consecutive wake words |
| tol_code | input | 2 | Tolerance code; allowed zero errors = 3 - tol_code |
| wake_pulse | output | 1 | One-clock pulse on a successful detection |

## Verification
The bench instantiates the block with its default parameters: 12 samples per half-bit, 16 half-bits, a 108-clock quiet timeout and a 2-bit tolerance field. These values let directed stimulus reach every boundary. That includes the 5-versus-6 inverted-sample vote limit, each of the four tolerance codes at and just past its error count, and the double-mode acceptance window. The window is probed with back-to-back words and with a two-half-bit gap. Because the timeout is much longer than the longest run inside the word, the bench can also show that a word starting from a long quiet high line is found through the level-following history.

// File: rtl/wcorr_pkg.sv
package wcorr_pkg;

   localparam int unsigned DEF_SAMPLES_PER_HALF = 12;
   localparam int unsigned DEF_HALF_BITS        = 16;
   localparam int unsigned DEF_TOL_W            = 2;
   localparam int unsigned DEF_IDLE_CYCLES      = 108;
   localparam logic [15:0] DEF_PATTERN          = 16'b1001_0110_0110_1001;

   typedef enum logic [0:0] {
      SEQ_SEARCH = 1'b0,
      SEQ_ARMED  = 1'b1
   } seq_state_e;

endpackage

// File: rtl/wcorr_activity.sv
module wcorr_activity #(
   parameter int unsigned IDLE_CYCLES = 108
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic line_in,
   output logic line_q,
   output logic transition,
   output logic active
);

   localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);

   logic          line_prev;
   logic [CW-1:0] quiet_cnt;

   assign transition = line_q ^ line_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q    <= 1'b0;
         line_prev <= 1'b0;
         quiet_cnt <= '0;
         active    <= 1'b0;
      end else if (!en) begin
         line_q    <= 1'b0;
         line_prev <= 1'b0;
         quiet_cnt <= '0;
         active    <= 1'b0;
      end else begin
         line_q    <= line_in;
         line_prev <= line_q;
         if (transition) begin
            quiet_cnt <= '0;
            active    <= 1'b1;
         end else if (active) begin
            if (quiet_cnt == CW'(IDLE_CYCLES - 1)) begin
               quiet_cnt <= '0;
               active    <= 1'b0;
            end else begin
               quiet_cnt <= quiet_cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/wcorr_window.sv
module wcorr_window #(
   parameter int unsigned SAMPLES_PER_HALF = 12,
   parameter int unsigned HALF_BITS        = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 run,
   input  logic                 line_q,
   output logic [HALF_BITS-1:0] hb_bits
);

   localparam int unsigned TOTAL = SAMPLES_PER_HALF * HALF_BITS;
   localparam int unsigned HALF  = SAMPLES_PER_HALF / 2;

   // sreg[0] holds the newest sample, sreg[TOTAL-1] the oldest
   logic [TOTAL-1:0] sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
      end else if (!en) begin
         sreg <= '0;
      end else if (run) begin
         sreg <= {sreg[TOTAL-2:0], line_q};
      end else begin
         sreg <= {TOTAL{line_q}};
      end
   end

   // one majority voter per half-bit; hb_bits MSB is the earliest half-bit
   for (genvar j = 0; j < HALF_BITS; j++) begin : g_vote
      logic [SAMPLES_PER_HALF-1:0] slice;
      assign slice = sreg[TOTAL-1-j*SAMPLES_PER_HALF -: SAMPLES_PER_HALF];
      assign hb_bits[HALF_BITS-1-j] = ($countones(slice) > HALF);
   end

endmodule

// File: rtl/wcorr_match.sv
module wcorr_match #(
   parameter int unsigned          HALF_BITS = 16,
   parameter int unsigned          TOL_W     = 2,
   parameter logic [HALF_BITS-1:0] PATTERN   = 16'b1001_0110_0110_1001
) (
   input  logic [HALF_BITS-1:0] hb_bits,
   input  logic [TOL_W-1:0]     tol_code,
   output logic                 hit
);

   localparam int unsigned EW = $clog2(HALF_BITS + 1);

   logic [HALF_BITS-1:0] lost_one;
   logic [HALF_BITS-1:0] stray_one;
   logic [EW-1:0]        stray_cnt;
   logic [TOL_W-1:0]     allowed;

   assign lost_one  = PATTERN & ~hb_bits;
   assign stray_one = ~PATTERN & hb_bits;
   assign stray_cnt = EW'($countones(stray_one));
   assign allowed   = {TOL_W{1'b1}} - tol_code;

   assign hit = (lost_one == '0) && (int'(stray_cnt) <= int'(allowed));

endmodule

// File: rtl/wcorr_seq.sv
module wcorr_seq import wcorr_pkg::*; #(
   parameter int unsigned SAMPLES_PER_HALF = 12,
   parameter int unsigned HALF_BITS        = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic active,
   input  logic match,
   input  logic double_mode,
   output logic armed,
   output logic wake
);

   localparam int unsigned WORD_CYC = SAMPLES_PER_HALF * HALF_BITS;
   localparam int unsigned WIN_LO   = WORD_CYC - SAMPLES_PER_HALF;
   localparam int unsigned WIN_HI   = WORD_CYC + SAMPLES_PER_HALF;
   localparam int unsigned CW       = $clog2(WIN_HI + 1);

   seq_state_e    state, state_n;
   logic [CW-1:0] cnt, cnt_n;
   logic          match_q;
   logic          fire;
   logic          wake_n;
   logic          in_win;

   assign fire   = match & ~match_q;
   assign in_win = (cnt >= CW'(WIN_LO)) && (cnt <= CW'(WIN_HI));
   assign armed  = (state == SEQ_ARMED);

   always_comb begin
      state_n = state;
      cnt_n   = (state == SEQ_ARMED) ? cnt + 1'b1 : '0;
      wake_n  = 1'b0;
      if (fire) begin
         if (!double_mode) begin
            wake_n = 1'b1;
         end else if (state == SEQ_ARMED && in_win) begin
            wake_n  = 1'b1;
            state_n = SEQ_SEARCH;
            cnt_n   = '0;
         end else begin
            state_n = SEQ_ARMED;
            cnt_n   = '0;
         end
      end else if (state == SEQ_ARMED && cnt >= CW'(WIN_HI)) begin
         state_n = SEQ_SEARCH;
         cnt_n   = '0;
      end
      if (!en || !active) begin
         state_n = SEQ_SEARCH;
         cnt_n   = '0;
         wake_n  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEQ_SEARCH;
         cnt     <= '0;
         match_q <= 1'b0;
         wake    <= 1'b0;
      end else begin
         state   <= state_n;
         cnt     <= cnt_n;
         match_q <= match;
         wake    <= wake_n;
      end
   end

endmodule

// File: rtl/wake_correlator.sv
module wake_correlator import wcorr_pkg::*; #(
   parameter int unsigned          SAMPLES_PER_HALF = DEF_SAMPLES_PER_HALF,
   parameter int unsigned          HALF_BITS        = DEF_HALF_BITS,
   parameter int unsigned          TOL_W            = DEF_TOL_W,
   parameter int unsigned          IDLE_CYCLES      = DEF_IDLE_CYCLES,
   parameter logic [HALF_BITS-1:0] PATTERN          = DEF_PATTERN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_in,
   input  logic             enable,
   input  logic             corr_off,
   input  logic             double_mode,
   input  logic [TOL_W-1:0] tol_code,
   output logic             wake_pulse
);

   if (SAMPLES_PER_HALF < 3) begin : g_bad_sph
      $error("SAMPLES_PER_HALF must be at least 3");
   end
   if (HALF_BITS < 2) begin : g_bad_hb
      $error("HALF_BITS must be at least 2");
   end
   if (SAMPLES_PER_HALF * HALF_BITS > 4096) begin : g_bad_depth
      $error("sample history too deep");
   end
   if (IDLE_CYCLES <= 2 * SAMPLES_PER_HALF) begin : g_bad_idle
      $error("IDLE_CYCLES must exceed the longest run inside the word");
   end
   if (TOL_W < 1 || TOL_W > 4) begin : g_bad_tol
      $error("TOL_W out of range");
   end

   logic                 line_w;
   logic                 transition_w;
   logic                 active_w;
   logic [HALF_BITS-1:0] hb_w;
   logic                 hit_w;
   logic                 match_w;
   logic                 armed_w;
   logic                 corr_en_w;

   assign corr_en_w = enable & ~corr_off;

   wcorr_activity #(
      .IDLE_CYCLES(IDLE_CYCLES)
   ) i_activity (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (enable),
      .line_in   (data_in),
      .line_q    (line_w),
      .transition(transition_w),
      .active    (active_w)
   );

   wcorr_window #(
      .SAMPLES_PER_HALF(SAMPLES_PER_HALF),
      .HALF_BITS       (HALF_BITS)
   ) i_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (enable),
      .run    (active_w | transition_w),
      .line_q (line_w),
      .hb_bits(hb_w)
   );

   wcorr_match #(
      .HALF_BITS(HALF_BITS),
      .TOL_W    (TOL_W),
      .PATTERN  (PATTERN)
   ) i_match (
      .hb_bits (hb_w),
      .tol_code(tol_code),
      .hit     (hit_w)
   );

   assign match_w = hit_w & active_w & corr_en_w;

   wcorr_seq #(
      .SAMPLES_PER_HALF(SAMPLES_PER_HALF),
      .HALF_BITS       (HALF_BITS)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (corr_en_w),
      .active     (active_w),
      .match      (match_w),
      .double_mode(double_mode),
      .armed      (armed_w),
      .wake       (wake_pulse)
   );

endmodule

// File: rtl/wcorr_checker.sv
module wcorr_checker (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic corr_off,
   input logic double_mode,
   input logic wake_pulse,
   input logic active,
   input logic match,
   input logic armed
);

   // R2: a wake is a single clock wide
   p_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   // R1: every wake is preceded by a pattern match
   p_wake_from_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> $past(match));

   // R8: no wake unless the channel was active
   p_wake_needs_activity_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> $past(active));

   // R9: switched off or disabled means silent
   p_off_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (corr_off || !enable) |=> !wake_pulse);

   // R6: a double-mode wake only comes from the armed state
   p_double_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_pulse && $past(double_mode)) |-> $past(armed));

endmodule

bind wake_correlator wcorr_checker i_wcorr_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .corr_off   (corr_off),
   .double_mode(double_mode),
   .wake_pulse (wake_pulse),
   .active     (active_w),
   .match      (match_w),
   .armed      (armed_w)
);

// File: tb/test_wake_correlator.sv
module test_wake_correlator;

   localparam logic [15:0] WORD = 16'b1001_0110_0110_1001;
   localparam int          NONE = -1;
   localparam int          ALL  = -2;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       data_in;
   logic       enable;
   logic       corr_off;
   logic       double_mode;
   logic [1:0] tol_code;
   logic       wake_pulse;

   int checks   = 0;
   int errors   = 0;
   int pulses   = 0;
   int cyc      = 0;
   int last_cyc = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   wake_correlator i_wake_correlator (
      .clk        (clk),
      .rst_n      (rst_n),
      .data_in    (data_in),
      .enable     (enable),
      .corr_off   (corr_off),
      .double_mode(double_mode),
      .tol_code   (tol_code),
      .wake_pulse (wake_pulse)
   );

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (wake_pulse === 1'b1) begin
         pulses   <= pulses + 1;
         last_cyc <= cyc;
      end
   end

   task automatic check_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_in(input string tag, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic hold(input logic v, input int n);
      data_in = v;
      repeat (n) @(negedge clk);
   endtask

   // cpos: half-bit index (0 = first sent), NONE or ALL; samples clo..chi inverted
   task automatic send_word(input logic [15:0] w, input int cpos, input int clo, input int chi);
      for (int j = 0; j < 16; j++) begin
         for (int s = 0; s < 12; s++) begin
            logic v;
            v = w[15-j];
            if ((cpos == j || cpos == ALL) && s >= clo && s <= chi) v = ~v;
            data_in = v;
            @(negedge clk);
         end
      end
   endtask

   task automatic one_word(input logic [15:0] w, input int cpos, input int clo, input int chi,
                           input logic [1:0] code, input int exp, input string tag);
      double_mode = 1'b0;
      tol_code    = code;
      pulses      = 0;
      send_word(w, cpos, clo, chi);
      hold(1'b0, 300);
      check_eq(tag, pulses, exp);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; data_in = 1'b0; enable = 1'b1; corr_off = 1'b0;
      double_mode = 1'b0; tol_code = 2'd2;
      repeat (6) @(negedge clk);
      check_eq("R2 wake low in reset", int'(wake_pulse), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_eq("R2 wake low after reset", int'(wake_pulse), 0);
   endtask

   task automatic t_single;
      int start;
      double_mode = 1'b0; tol_code = 2'd2; pulses = 0;
      start = cyc;
      send_word(WORD, NONE, 0, 0);
      hold(1'b0, 300);
      check_eq("R1 clean word single pulse", pulses, 1);
      check_in("R1 wake latency", last_cyc - start, 182, 196);
      check_eq("R2 pulse one clock wide", pulses, 1);
   endtask

   task automatic t_tolerance;
      // zero positions 1,4,7,11 sit at word bits 14,11,8,4
      one_word(WORD ^ 16'h4900, NONE, 0, 0, 2'd0, 1, "R3 code0 three errors");
      one_word(WORD ^ 16'h4910, NONE, 0, 0, 2'd0, 0, "R3 code0 four errors");
      one_word(WORD ^ 16'h4800, NONE, 0, 0, 2'd1, 1, "R3 code1 two errors");
      one_word(WORD ^ 16'h4900, NONE, 0, 0, 2'd1, 0, "R3 code1 three errors");
      one_word(WORD ^ 16'h4000, NONE, 0, 0, 2'd2, 1, "R3 code2 one error");
      one_word(WORD ^ 16'h4800, NONE, 0, 0, 2'd2, 0, "R3 code2 two errors");
      one_word(WORD,            NONE, 0, 0, 2'd3, 1, "R3 code3 clean");
      one_word(WORD ^ 16'h4000, NONE, 0, 0, 2'd3, 0, "R3 code3 one error");
   endtask

   task automatic t_ones;
      // one-position 5 sits at word bit 10
      one_word(WORD ^ 16'h0400, NONE, 0, 0, 2'd0, 0, "R4 lost one rejected");
   endtask

   task automatic t_majority;
      one_word(WORD, ALL, 3, 7, 2'd3, 1, "R5 five bad samples per half-bit");
      one_word(WORD, 0, 3, 8, 2'd0, 0, "R5 six bad samples in a one");
   endtask

   task automatic t_double;
      int start;
      double_mode = 1'b1; tol_code = 2'd2; pulses = 0;
      send_word(WORD, NONE, 0, 0);
      hold(1'b0, 300);
      check_eq("R6 single word in double mode", pulses, 0);
      pulses = 0;
      start = cyc;
      send_word(WORD, NONE, 0, 0);
      send_word(WORD, NONE, 0, 0);
      hold(1'b0, 300);
      check_eq("R6 two words one pulse", pulses, 1);
      check_in("R6 pulse after second word", last_cyc - start, 374, 388);
   endtask

   task automatic t_double_tol;
      double_mode = 1'b1; tol_code = 2'd2; pulses = 0;
      send_word(WORD ^ 16'h4000, NONE, 0, 0);
      send_word(WORD ^ 16'h0800, NONE, 0, 0);
      hold(1'b0, 300);
      check_eq("R7 one error in each word", pulses, 1);
      pulses = 0;
      send_word(WORD, NONE, 0, 0);
      send_word(WORD ^ 16'h4800, NONE, 0, 0);
      hold(1'b0, 300);
      check_eq("R7 second word over budget", pulses, 0);
   endtask

   task automatic t_late_second;
      double_mode = 1'b1; tol_code = 2'd2; pulses = 0;
      send_word(WORD, NONE, 0, 0);
      hold(1'b0, 24);
      send_word(WORD, NONE, 0, 0);
      hold(1'b0, 300);
      check_eq("R10 gapped second word", pulses, 0);
   endtask

   task automatic t_quiet_line;
      double_mode = 1'b0; tol_code = 2'd2; pulses = 0;
      hold(1'b1, 300);
      check_eq("R8 quiet high line no wake", pulses, 0);
      send_word(WORD, NONE, 0, 0);
      hold(1'b0, 300);
      check_eq("R8 word after long high rest", pulses, 1);
      pulses = 0;
      hold(1'b0, 400);
      send_word(WORD, NONE, 0, 0);
      hold(1'b0, 300);
      check_eq("R8 word after long low rest", pulses, 1);
   endtask

   task automatic t_off;
      double_mode = 1'b0; tol_code = 2'd2;
      corr_off = 1'b1; pulses = 0;
      send_word(WORD, NONE, 0, 0);
      hold(1'b0, 300);
      check_eq("R9 correlator off", pulses, 0);
      corr_off = 1'b0; enable = 1'b0; pulses = 0;
      send_word(WORD, NONE, 0, 0);
      hold(1'b0, 300);
      check_eq("R9 channel disabled", pulses, 0);
      enable = 1'b1; pulses = 0;
      hold(1'b0, 20);
      send_word(WORD, NONE, 0, 0);
      hold(1'b0, 300);
      check_eq("R9 restored channel wakes", pulses, 1);
   endtask

   initial begin
      t_reset();
      t_single();
      t_tolerance();
      t_ones();
      t_majority();
      t_double();
      t_double_tol();
      t_late_second();
      t_quiet_line();
      t_off();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule